// File: doc/BRIEF.md
# Power-Down and Wakeup Sequencer

This block controls the clocks of a small microcontroller subsystem. When the CPU requests sleep by writing 1 to the power-down bit (a single-cycle `sleep_req` pulse), the sequencer turns off the oscillator enable, the PLL enable and the core clock gate. It then waits for an enabled wake source. The sequencer runs on a slow, always-on clock, so it keeps working while the main clocks are stopped. Wait lengths are counted in cycles of this clock.

There are three wake sources, each with its own enable bit. Bit 0 is bus activity, bit 1 is a dedicated wake pin and bit 2 is a second wake pin that can also serve as a general-purpose I/O. When a source fires, the restart runs in a fixed order. The oscillator starts first and is given a programmable settle time. The PLL starts next and is given a programmable lock time. Only then is the core clock released and a wakeup interrupt raised. The interrupt stays pending until the CPU clears it. A status vector records which sources caused the wakeup. The behaviour is the same whether or not the bus interface is attached.

The states are `ST_RUN`, `ST_SLEEP`, `ST_OSC_WAIT` and `ST_PLL_WAIT`. The transitions are:
- RUN→SLEEP on `sleep_req`.
- SLEEP→OSC_WAIT on any qualified wake hit.
- OSC_WAIT→PLL_WAIT when the oscillator timer expires.
- PLL_WAIT→RUN when the lock timer expires.

Top module: `pwr_wake_seq`

## Requirements
- R1: After reset the block is in RUN: `osc_en`, `pll_en` and `core_clk_en` are 1, while `wake_irq`, `pd_bit` and `wake_src` are 0.
- R2: A `sleep_req` pulse in RUN makes `osc_en`, `pll_en` and `core_clk_en` 0 and `pd_bit` 1 from the next cycle. The block stays in this state until a qualified wake hit.
- R3: Source bit 0 is `bus_act` (active high), bit 1 is `pin_a` and bit 2 is `pin_b`. Each passes a two-flop synchronizer and counts only if its `wake_en` bit is 1. A hit that is present before clock edge k turns `osc_en` on after edge k+2.
- R4: `pin_a_pol`=0 makes `pin_a` active low (the default use) and 1 makes it active high. `pin_b_pol` selects the polarity of `pin_b` in the same way.
- R5: While `pin_b_gpio`=1, `pin_b` never wakes the block.
- R6: In OSC_WAIT, `osc_en`=1, `pll_en`=0 and `core_clk_en`=0 for exactly `osc_wait`+1 cycles. A value of 0 gives one cycle.
- R7: In PLL_WAIT, `osc_en`=1, `pll_en`=1 and `core_clk_en`=0 for exactly `pll_wait`+1 cycles. After that, `core_clk_en` returns to 1.
- R8: `wake_irq` becomes 1 and `pd_bit` becomes 0 in the same cycle that `core_clk_en` returns to 1. `wake_irq` stays 1 until an `irq_clr` pulse clears it.
- R9: `wake_src` takes the set of qualified sources that were active when SLEEP was left, with one bit per source index. It holds that value until the next exit from SLEEP.
- R10: Wake events during OSC_WAIT or PLL_WAIT are ignored: the restart timing and `wake_src` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-speed clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Pulse: CPU writes 1 to the power-down bit |
| irq_clr | input | 1 | Pulse: CPU writes 1 to clear the wakeup interrupt |
| wake_en | input | 3 | Per-source wake enables (bus, pin_a, pin_b) |
| pin_a_pol | input | 1 | Polarity of the dedicated pin; 1 = active high |
| pin_b_pol | input | 1 | Polarity of the shared pin; 1 = active high |
| pin_b_gpio | input | 1 | The shared pin is used as GPIO and cannot wake |
| osc_wait | input | CNT_W | Oscillator settle cycles minus one |
| pll_wait | input | CNT_W | PLL lock cycles minus one |
| bus_act | input | 1 | Bus-activity detect |
| pin_a | input | 1 | Dedicated wake pin |
| pin_b | input | 1 | Shared wake / GPIO pin |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| core_clk_en | output | 1 | Core clock gate enable |
| wake_irq | output | 1 | Pending wakeup interrupt |
| pd_bit | output | 1 | Read-back of the power-down bit |
| wake_src | output | 3 | Sources that caused the last wakeup |

## Verification
The bench targets the cycle count of each restart phase, including a zero-length settle setting. A timer off by one would release the core a cycle early or late. Masked wakeups are covered by a disabled source and by the shared pin in GPIO mode; either one leaking through would wake the block when it should stay asleep. Both polarity settings are tried on each pin, and an inverted polarity would wake the block at once or never. A bus pulse during the oscillator wait checks that late events are ignored; a design that restarted on it would stretch the sequence or overwrite `wake_src`.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    localparam int NSRC    = 3;
    localparam int SRC_BUS = 0;
    localparam int SRC_PA  = 1;
    localparam int SRC_PB  = 2;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SLEEP,
        ST_OSC_WAIT,
        ST_PLL_WAIT
    } pwr_state_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int           N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] synced
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                sync_q <= RST_VAL[g];
            end else begin
                meta_q <= raw[g];
                sync_q <= meta_q;
            end
        end
        assign synced[g] = sync_q;
    end
endmodule

// File: rtl/wake_qual.sv
module wake_qual
    import pwr_pkg::*;
(
    input  logic [NSRC-1:0] synced,
    input  logic [NSRC-1:0] en,
    input  logic            pol_a,
    input  logic            pol_b,
    input  logic            b_gpio,
    output logic [NSRC-1:0] hit
);
    logic [NSRC-1:0] act_hi;
    logic [NSRC-1:0] allow;

    always_comb begin
        act_hi         = '1;
        act_hi[SRC_PA] = pol_a;
        act_hi[SRC_PB] = pol_b;
        allow          = '1;
        allow[SRC_PB]  = ~b_gpio;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = ~(synced[g] ^ act_hi[g]) & en[g] & allow[g];
    end
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (cnt_q != {W{1'b1}})
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q >= limit);
endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq
    import pwr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             irq_clr,
    input  logic [NSRC-1:0]  wake_en,
    input  logic             pin_a_pol,
    input  logic             pin_b_pol,
    input  logic             pin_b_gpio,
    input  logic [CNT_W-1:0] osc_wait,
    input  logic [CNT_W-1:0] pll_wait,
    input  logic             bus_act,
    input  logic             pin_a,
    input  logic             pin_b,
    output logic             osc_en,
    output logic             pll_en,
    output logic             core_clk_en,
    output logic             wake_irq,
    output logic             pd_bit,
    output logic [NSRC-1:0]  wake_src
);
    localparam logic [NSRC-1:0] SYNC_RST = NSRC'(1 << SRC_PA);

    pwr_state_e      state_q, state_d;
    logic [NSRC-1:0] raw, synced, hit;
    logic [CNT_W-1:0] tmr_limit;
    logic            tmr_clr, tmr_done;
    logic            irq_q;
    logic [NSRC-1:0] src_q;

    assign raw = {pin_b, pin_a, bus_act};

    wake_sync #(.N(NSRC), .RST_VAL(SYNC_RST)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw),
        .synced (synced)
    );

    wake_qual u_qual (
        .synced (synced),
        .en     (wake_en),
        .pol_a  (pin_a_pol),
        .pol_b  (pin_b_pol),
        .b_gpio (pin_b_gpio),
        .hit    (hit)
    );

    assign tmr_limit = (state_q == ST_PLL_WAIT) ? pll_wait : osc_wait;
    assign tmr_clr   = (state_d != state_q);

    wait_timer #(.W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:      if (sleep_req) state_d = ST_SLEEP;
            ST_SLEEP:    if (|hit)      state_d = ST_OSC_WAIT;
            ST_OSC_WAIT: if (tmr_done)  state_d = ST_PLL_WAIT;
            ST_PLL_WAIT: if (tmr_done)  state_d = ST_RUN;
            default:                    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            src_q <= '0;
        end else begin
            if (state_q == ST_PLL_WAIT && tmr_done)
                irq_q <= 1'b1;
            else if (irq_clr)
                irq_q <= 1'b0;
            if (state_q == ST_SLEEP && |hit)
                src_q <= hit;
        end
    end

    always_comb begin
        osc_en      = 1'b0;
        pll_en      = 1'b0;
        core_clk_en = 1'b0;
        pd_bit      = 1'b1;
        unique case (state_q)
            ST_RUN: begin
                osc_en      = 1'b1;
                pll_en      = 1'b1;
                core_clk_en = 1'b1;
                pd_bit      = 1'b0;
            end
            ST_SLEEP:    ;
            ST_OSC_WAIT: osc_en = 1'b1;
            ST_PLL_WAIT: begin
                osc_en = 1'b1;
                pll_en = 1'b1;
            end
            default:     ;
        endcase
    end

    assign wake_irq = irq_q;
    assign wake_src = src_q;
endmodule

// File: rtl/pwr_wake_seq_chk.sv
module pwr_wake_seq_chk
    import pwr_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            irq_clr,
    input logic            osc_en,
    input logic            pll_en,
    input logic            core_clk_en,
    input logic            wake_irq,
    input logic            pd_bit,
    input logic [NSRC-1:0] wake_src
);
    // R7
    core_needs_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> (osc_en && pll_en));

    // R7
    pll_before_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> $past(pll_en));

    // R8
    irq_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> (wake_irq && !pd_bit));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq && !irq_clr) |=> wake_irq);

    // R6
    osc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> (!pll_en && !core_clk_en));

    // R2
    sleep_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> (pd_bit && !pll_en && !core_clk_en));

    // R10
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && !core_clk_en) |=> $stable(wake_src));
endmodule

bind pwr_wake_seq pwr_wake_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_clr     (irq_clr),
    .osc_en      (osc_en),
    .pll_en      (pll_en),
    .core_clk_en (core_clk_en),
    .wake_irq    (wake_irq),
    .pd_bit      (pd_bit),
    .wake_src    (wake_src)
);

// File: tb/pwr_wake_seq_tb.sv
module pwr_wake_seq_tb_top;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_req = 1'b0, irq_clr = 1'b0;
    logic [2:0]    wake_en = 3'b111;
    logic          pin_a_pol = 1'b0, pin_b_pol = 1'b1, pin_b_gpio = 1'b0;
    logic [CW-1:0] osc_wait = 16'd3, pll_wait = 16'd2;
    logic          bus_act = 1'b0, pin_a = 1'b1, pin_b = 1'b0;
    logic          osc_en, pll_en, core_clk_en, wake_irq, pd_bit;
    logic [2:0]    wake_src;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pwr_wake_seq #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .irq_clr(irq_clr),
        .wake_en(wake_en), .pin_a_pol(pin_a_pol), .pin_b_pol(pin_b_pol),
        .pin_b_gpio(pin_b_gpio), .osc_wait(osc_wait), .pll_wait(pll_wait),
        .bus_act(bus_act), .pin_a(pin_a), .pin_b(pin_b),
        .osc_en(osc_en), .pll_en(pll_en), .core_clk_en(core_clk_en),
        .wake_irq(wake_irq), .pd_bit(pd_bit), .wake_src(wake_src)
    );

    // fields: [15:13] en, [12] pol_a, [11] pol_b, [10] gpio,
    //         [9:7] idle pins, [6:4] stim pins, [3] wakes, [2:0] expected src
    // pin bit order: [2] pin_b, [1] pin_a, [0] bus_act
    localparam logic [15:0] VECS [9] = '{
        {3'b111, 1'b0, 1'b1, 1'b0, 3'b010, 3'b011, 1'b1, 3'b001},
        {3'b111, 1'b0, 1'b1, 1'b0, 3'b010, 3'b000, 1'b1, 3'b010},
        {3'b111, 1'b0, 1'b1, 1'b0, 3'b010, 3'b110, 1'b1, 3'b100},
        {3'b111, 1'b1, 1'b1, 1'b0, 3'b000, 3'b010, 1'b1, 3'b010},
        {3'b111, 1'b0, 1'b0, 1'b0, 3'b110, 3'b010, 1'b1, 3'b100},
        {3'b111, 1'b0, 1'b1, 1'b1, 3'b010, 3'b110, 1'b0, 3'b000},
        {3'b101, 1'b0, 1'b1, 1'b0, 3'b010, 3'b000, 1'b0, 3'b000},
        {3'b111, 1'b0, 1'b1, 1'b0, 3'b010, 3'b111, 1'b1, 3'b101},
        {3'b110, 1'b0, 1'b1, 1'b0, 3'b010, 3'b011, 1'b0, 3'b000}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_pins(input logic [2:0] p);
        {pin_b, pin_a, bus_act} = p;
    endtask

    task automatic go_sleep();
        sleep_req = 1'b1;
        cyc(1);
        sleep_req = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        cyc(1);
        irq_clr = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        // R1 reset state
        check("R1 clocks", {29'd0, osc_en, pll_en, core_clk_en}, 32'd7);
        check("R1 irq/pd", {30'd0, wake_irq, pd_bit}, 32'd0);
        check("R1 src", {29'd0, wake_src}, 32'd0);

        // R2 sleep entry, then R3 R6 R7 R8 timing with osc_wait=3, pll_wait=2
        go_sleep();
        check("R2 sleep outputs", {28'd0, osc_en, pll_en, core_clk_en, pd_bit}, 32'd1);
        cyc(4);
        check("R2 stays asleep", {31'd0, osc_en}, 32'd0);
        set_pins(3'b011);
        cyc(2);
        check("R3 sync latency", {31'd0, osc_en}, 32'd0);
        cyc(1);
        check("R6 osc phase", {29'd0, osc_en, pll_en, core_clk_en}, 32'd4);
        set_pins(3'b010);
        cyc(1);
        set_pins(3'b011);   // R10 late event during OSC_WAIT
        cyc(1);
        set_pins(3'b010);
        cyc(1);
        check("R6 osc last cycle", {29'd0, osc_en, pll_en, core_clk_en}, 32'd4);
        cyc(1);
        check("R7 pll phase", {29'd0, osc_en, pll_en, core_clk_en}, 32'd6);
        cyc(2);
        check("R7 pll last cycle", {29'd0, osc_en, pll_en, core_clk_en}, 32'd6);
        check("R10 timing unchanged", {31'd0, wake_irq}, 32'd0);
        cyc(1);
        check("R7 core released", {31'd0, core_clk_en}, 32'd1);
        check("R8 irq and pd", {30'd0, wake_irq, pd_bit}, 32'd2);
        check("R10 src unchanged", {29'd0, wake_src}, 32'd1);
        cyc(3);
        check("R8 irq held", {31'd0, wake_irq}, 32'd1);
        clear_irq();
        check("R8 irq cleared", {31'd0, wake_irq}, 32'd0);

        // R6 R7 zero-length waits
        osc_wait = '0;
        pll_wait = '0;
        go_sleep();
        set_pins(3'b011);
        cyc(4);
        set_pins(3'b010);
        check("R7 zero wait pll", {29'd0, osc_en, pll_en, core_clk_en}, 32'd6);
        cyc(1);
        check("R6 zero wait release", {30'd0, core_clk_en, wake_irq}, 32'd3);
        clear_irq();
        osc_wait = 16'd3;
        pll_wait = 16'd2;

        // vector table: R3 R4 R5 R9
        for (int i = 0; i < 9; i++) begin
            logic [15:0] v;
            v = VECS[i];
            wake_en    = v[15:13];
            pin_a_pol  = v[12];
            pin_b_pol  = v[11];
            pin_b_gpio = v[10];
            set_pins(v[9:7]);
            cyc(3);
            go_sleep();
            cyc(2);
            set_pins(v[6:4]);
            cyc(12);
            check($sformatf("R3 R4 R5 vec%0d wake", i), {31'd0, ~pd_bit}, {31'd0, v[3]});
            if (v[3]) begin
                check($sformatf("R9 vec%0d src", i), {29'd0, wake_src}, {29'd0, v[2:0]});
            end else begin
                wake_en = 3'b001;
                set_pins(v[9:7] | 3'b001);
                cyc(12);
                set_pins(v[9:7]);
            end
            clear_irq();
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule